// File: doc/BRIEF.md
# Cascaded Clock-Enable Generator with FM/MFM Rate Select

This block derives a family of one-cycle enable strobes from a single fast system clock (about 32 MHz) so that a floppy-style disk controller can run entirely in that one clock domain. No divided clock is ever produced: every output is a pulse that is high for exactly one system cycle, and downstream flip-flops use it as a clock enable. Because all logic shares one clock, no clock-domain crossing exists anywhere.

The strobes come from three cascaded stages whose advance conditions are combined by logical AND. The first stage fires once every four active system cycles and stands for an 8 MHz controller clock. The second stage produces the drive-interface strobe: in MFM mode it repeats every first-stage strobe, and in FM mode it keeps only every second one. The third stage divides the drive-interface strobe by sixteen and emits two slow strobes of equal rate (0.5 MHz in MFM, 0.25 MHz in FM), the second lagging the first by half a slow period. A top-level run input pauses the whole chain, and the mode input is only adopted at drive-interface boundaries so a pulse spacing is never cut short.

Top module: `clkena_cascade`

## Requirements
- R1: While rst is high all four strobes are low; after rst falls, with run held high, the first ctl_en pulse appears in the fourth clock cycle (cycle index 3, counting the first cycle after release as 0).
- R2: With run high, ctl_en pulses once every PRE_DIV (4) cycles and is never high on two consecutive cycles.
- R3: With the adopted mode MFM (mfm = 1), drv_en is high in exactly the cycles where ctl_en is high.
- R4: With the adopted mode FM (mfm = 0), drv_en is high on every second ctl_en pulse, the first being the second ctl_en after reset or after the last drv_en; drv_en is never high without ctl_en.
- R5: slow_a fires on the first drv_en after reset and then on every SLOW_DIV-th (16th) drv_en, giving periods of 64 cycles in MFM and 128 cycles in FM.
- R6: slow_b fires on the drv_en that is PHASE_B (8) drv_en pulses after each slow_a, so slow_a and slow_b are never high together.
- R7: While run is low no strobe is high and no divider advances, so resuming continues the exact phase at which it stopped.
- R8: A new value on mfm is adopted only in the cycle after a drv_en pulse (or during reset); a change at any other time does not alter the spacing of pulses until that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; also samples the mode |
| run | input | 1 | Top-level enable; low pauses every stage |
| mfm | input | 1 | Rate select: 1 = MFM (no halving), 0 = FM (halve) |
| ctl_en | output | 1 | Controller-rate strobe |
| drv_en | output | 1 | Drive-interface-rate strobe |
| slow_a | output | 1 | Slow strobe, phase 0 |
| slow_b | output | 1 | Slow strobe, half a slow period after slow_a |

## Verification
The hardest situation to reach is a mode flip arriving in the middle of an FM pair, where the adopted mode must stay FM until the pending drive strobe has fired, combined with run dropping between the two halves. The stimulus reaches it with a long sweep in which run and mfm are driven from two independent pseudo-random sequences with different periods, so mode flips land at every offset relative to the dividers and pauses split every stage; a cycle-by-cycle reference derived from the requirements is compared on every cycle, and fixed-mode runs check the absolute pulse cycles arithmetically.

// File: rtl/clkena_cascade.sv
module clkena_cascade #(
  parameter int PRE_DIV  = 4,
  parameter int SLOW_DIV = 16,
  parameter int PHASE_B  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic mfm,
  output logic ctl_en,
  output logic drv_en,
  output logic slow_a,
  output logic slow_b
);
  localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int SW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
  localparam logic [SW-1:0] SLOW_B_AT = SW'(PHASE_B);

  logic [PW-1:0] pre;
  logic [SW-1:0] slow;
  logic          half;
  logic          mode_q;

  assign ctl_en = run & ~rst & (pre == PRE_LAST);
  assign drv_en = ctl_en & (mode_q | half);
  assign slow_a = drv_en & (slow == '0);
  assign slow_b = drv_en & (slow == SLOW_B_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      slow   <= '0;
      half   <= 1'b0;
      mode_q <= mfm;
    end else begin
      if (run)
        pre <= (pre == PRE_LAST) ? '0 : pre + PW'(1);
      if (ctl_en)
        half <= ~drv_en;
      if (drv_en) begin
        mode_q <= mfm;
        slow   <= (slow == SLOW_LAST) ? '0 : slow + SW'(1);
      end
    end
  end
endmodule

// File: rtl/clkena_cascade_chk.sv
module clkena_cascade_chk #(
  parameter int PW = 2,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          ctl_en,
  input logic          drv_en,
  input logic          slow_a,
  input logic          slow_b,
  input logic [PW-1:0] pre,
  input logic [SW-1:0] slow,
  input logic          mode_q
);
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_en |=> !ctl_en);
  p_drv_in_ctl_r4: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> ctl_en);
  p_slow_in_drv_r5: assert property (@(posedge clk) disable iff (rst)
    (slow_a || slow_b) |-> drv_en);
  p_ab_apart_r6: assert property (@(posedge clk) disable iff (rst)
    !(slow_a && slow_b));
  p_quiet_paused_r7: assert property (@(posedge clk) disable iff (rst)
    !run |-> !(ctl_en || drv_en || slow_a || slow_b));
  p_hold_paused_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pre) && $stable(slow)));
  p_mode_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    !drv_en |=> $stable(mode_q));
endmodule

bind clkena_cascade clkena_cascade_chk #(.PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ctl_en(ctl_en), .drv_en(drv_en),
  .slow_a(slow_a), .slow_b(slow_b), .pre(pre), .slow(slow), .mode_q(mode_q)
);

// File: tb/sim_clkena_cascade.sv
module sim_clkena_cascade;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, mfm = 1'b1;
  logic ctl_en, drv_en, slow_a, slow_b;

  clkena_cascade u0 (.clk(clk), .rst(rst), .run(run), .mfm(mfm),
    .ctl_en(ctl_en), .drv_en(drv_en), .slow_a(slow_a), .slow_b(slow_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int k;
  int m_pre, m_slow, m_half, m_mode;
  int first_ctl, first_drv, a_hits[$], b_hits[$];

  task automatic check(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at k=%0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; run = 1'b1; mfm = m;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", ctl_en | drv_en | slow_a | slow_b, 1'b0, "strobe in reset");
    end
    rst = 1'b0;
    m_pre = 0; m_slow = 0; m_half = 0; m_mode = m;
    k = 0; first_ctl = -1; first_drv = -1;
    a_hits.delete(); b_hits.delete();
  endtask

  // one cycle: drive inputs, compare to requirement-derived expectation, advance
  task automatic step(input logic r, input logic m);
    logic e_ctl, e_drv, e_a, e_b;
    run = r; mfm = m;
    #1;
    e_ctl = r && (m_pre == 3);
    e_drv = e_ctl && (m_mode == 1 || m_half == 1);
    e_a   = e_drv && (m_slow == 0);
    e_b   = e_drv && (m_slow == 8);
    check("R2", ctl_en, e_ctl, "ctl_en");
    check(m_mode == 1 ? "R3" : "R4", drv_en, e_drv, "drv_en");
    check("R5", slow_a, e_a, "slow_a");
    check("R6", slow_b, e_b, "slow_b");
    if (!r) check("R7", ctl_en | drv_en | slow_a | slow_b, 1'b0, "strobe while paused");
    if (ctl_en && first_ctl < 0) first_ctl = k;
    if (drv_en && first_drv < 0) first_drv = k;
    if (slow_a) a_hits.push_back(k);
    if (slow_b) b_hits.push_back(k);
    if (r) m_pre = (m_pre + 1) % 4;
    if (e_ctl) m_half = e_drv ? 0 : 1;
    if (e_drv) begin
      m_mode = m;                    // R8: adopted only at a drive boundary
      m_slow = (m_slow + 1) % 16;
    end
    k++;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // MFM, run held high: absolute pulse positions
    do_reset(1'b1);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1);
    check_int("R1", first_ctl, 3, "first ctl_en cycle");
    check_int("R3", first_drv, 3, "first drv_en cycle (MFM)");
    check_int("R5", a_hits[0], 3, "first slow_a (MFM)");
    check_int("R5", a_hits[1] - a_hits[0], 64, "slow_a period (MFM)");
    check_int("R6", b_hits[0], 35, "first slow_b (MFM)");

    // FM, run held high
    do_reset(1'b0);
    for (int i = 0; i < 400; i++) step(1'b1, 1'b0);
    check_int("R1", first_ctl, 3, "first ctl_en cycle (FM)");
    check_int("R4", first_drv, 7, "first drv_en cycle (FM)");
    check_int("R5", a_hits[0], 7, "first slow_a (FM)");
    check_int("R5", a_hits[1] - a_hits[0], 128, "slow_a period (FM)");
    check_int("R6", b_hits[0], 71, "first slow_b (FM)");

    // FM with a pause: phase resumes where it stopped
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    check_int("R7", first_drv, 7 + 9, "first drv_en after 9-cycle pause");

    // FM, mode flipped to MFM right after first ctl_en (mid pair): no early drv_en
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
    check_int("R8", first_drv, 7, "drv_en after mid-pair flip");

    // long mixed sweep with independent pseudo-random run and mode
    for (int s = 0; s < 3; s++) begin
      logic [6:0] lr; logic [8:0] lm;
      do_reset(s[0]);
      lr = 7'h5a + 7'(s); lm = 9'h11d + 9'(s);
      for (int i = 0; i < 20000; i++) begin
        lr = {lr[5:0], lr[6] ^ lr[5]};
        if (i % 23 == 0) lm = {lm[7:0], lm[8] ^ lm[4]};
        step(lr[0] | lr[2] | (s == 2), lm[0]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule